// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block watches the line-address read requests that the upper cache levels pass down and learns sequential access patterns within each 4 KB physical page. A page that sees two unit steps in a row in the same direction holds a confirmed stream. Every later request that continues that stream makes the block issue prefetch line addresses further along the stream, up to two per request. The block never issues an address outside the page of the request that caused it.

The count of outstanding demand requests sets how far the prefetch position may run ahead of demand. When few requests are outstanding, the block reaches far ahead. When many are outstanding, it stays close and sends every prefetch to the last-level cache only. A prefetch that lands far ahead of demand is also sent to the last-level cache only, so that it does not displace useful mid-level lines.

Control is a three-state issue machine. In `ST_IDLE` the block accepts a request, updates the stream table and latches up to two prefetch candidates. The transition idle→send-first happens when at least one candidate exists. `ST_SEND_A` presents the first candidate and moves to `ST_SEND_B` on a handshake when a second candidate was latched, or back to idle otherwise. `ST_SEND_B` presents the second candidate and returns to idle on its handshake.

Top module: `stream_prefetcher`

## Requirements
- R1: The first request to a page, and any request that only begins training, issues nothing. A direction is confirmed when a request is the second consecutive step of +1 (or −1) line offset within the page, and that request issues prefetches.
- R2: A confirmed forward stream issues ascending offsets. On confirmation at offset o the first prefetch is o+1. Afterwards each request at offset o resumes from the larger of o+1 and the stored forward position.
- R3: A confirmed backward stream mirrors R2 with descending offsets. It starts at o−1 and resumes from the smaller of o−1 and the stored backward position.
- R4: At most two prefetches are issued for one accepted request.
- R5: Page size is 64 lines (line offset is the low 6 bits of the line address). Every prefetch keeps the upper bits of the request and an offset in 0..63. A stream stops at offset 63 forward or 0 backward.
- R6: A prefetch is issued only while its distance from the request offset is at most D. D is 20 when outstanding ≤ 2, 10 when outstanding is 3..7, and 5 when outstanding ≥ 8.
- R7: pf_llc_only is 1 when the distance exceeds 8 lines or when outstanding ≥ 8, and 0 otherwise.
- R8: A request in a tracked page whose step is not +1 clears forward training and confirmation. A step that is not −1 clears backward training and confirmation.
- R9: The table holds 16 pages, each with one forward and one backward stream (32 streams). A request to an untracked page takes a free entry, or the least recently used one when the table is full.
- R10: req_ready is high only in idle, and requests presented while prefetches are pending are ignored. pf_valid stays high with pf_line and pf_llc_only stable until pf_ready.
- R11: After reset, pf_valid is 0, req_ready is 1 and no page is tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Demand request strobe |
| req_line | input | LINE_W | Demand line address |
| req_outstanding | input | OUT_W | Number of outstanding demand requests |
| req_ready | output | 1 | Block is idle and takes a request |
| pf_valid | output | 1 | Prefetch address present |
| pf_line | output | LINE_W | Prefetch line address |
| pf_llc_only | output | 1 | 1: fill last-level cache only; 0: fill both levels |
| pf_ready | input | 1 | Consumer takes the prefetch |

## Verification
The assertions measure prefetch distance and page against the most recently accepted request. This assumes the request interface is sampled only when req_ready is high. It also assumes the outstanding count seen at that acceptance is the one that governs the prefetches that follow. The stimulus drives a request only after all pending prefetches have drained and holds the outstanding count for the whole exchange. The one exception is a deliberate request pulse during a stalled send, which the block must discard. pf_ready is high in every phase except the stall, so the hold property is exercised without leaving a prefetch pending forever.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND_A = 2'd1,
        ST_SEND_B = 2'd2
    } issue_state_t;

    localparam logic [1:0] CNT_CONF = 2'd2;

    function automatic logic [1:0] cnt_bump(input logic [1:0] c);
        return (c >= CNT_CONF) ? CNT_CONF : c + 2'd1;
    endfunction

endpackage

// File: rtl/pf_depth_policy.sv
module pf_depth_policy #(
    parameter int OUT_W     = 5,
    parameter int DIST_W    = 7,
    parameter int MAX_AHEAD = 20,
    parameter int LOW_OUT   = 2,
    parameter int HIGH_OUT  = 8
) (
    input  logic [OUT_W-1:0]  outstanding,
    output logic [DIST_W-1:0] dist_lim,
    output logic              crowded
);
    localparam int MID_AHEAD  = MAX_AHEAD / 2;
    localparam int NEAR_AHEAD = (MAX_AHEAD / 4 > 0) ? MAX_AHEAD / 4 : 1;

    localparam logic [OUT_W-1:0]  LOW_LIM  = OUT_W'(LOW_OUT);
    localparam logic [OUT_W-1:0]  HIGH_LIM = OUT_W'(HIGH_OUT);
    localparam logic [DIST_W-1:0] D_FAR    = DIST_W'(MAX_AHEAD);
    localparam logic [DIST_W-1:0] D_MID    = DIST_W'(MID_AHEAD);
    localparam logic [DIST_W-1:0] D_NEAR   = DIST_W'(NEAR_AHEAD);

    always_comb begin
        crowded  = 1'b0;
        dist_lim = D_MID;
        if (outstanding >= HIGH_LIM) begin
            crowded  = 1'b1;
            dist_lim = D_NEAR;
        end else if (outstanding <= LOW_LIM) begin
            dist_lim = D_FAR;
        end
    end

endmodule

// File: rtl/pf_stream_table.sv
module pf_stream_table
    import pf_pkg::*;
#(
    parameter int LINE_W = 20,
    parameter int OFF_W  = 6,
    parameter int PAGES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [LINE_W-1:0] req_line,
    input  logic [OFF_W:0]    dist_lim,
    output logic [1:0]        issue_cnt,
    output logic [LINE_W-1:0] line_a,
    output logic [LINE_W-1:0] line_b,
    output logic [OFF_W:0]    ahead_a,
    output logic [OFF_W:0]    ahead_b
);
    localparam int TAG_W = LINE_W - OFF_W;
    localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam int PTR_W = OFF_W + 2;

    localparam logic [IDX_W-1:0]        OLDEST = IDX_W'(PAGES - 1);
    localparam logic signed [PTR_W-1:0] ONE_S  = PTR_W'(1);
    localparam logic signed [PTR_W-1:0] ZERO_S = '0;
    localparam logic signed [PTR_W-1:0] LAST_S = PTR_W'((1 << OFF_W) - 1);

    logic                     val_q  [PAGES];
    logic [TAG_W-1:0]         tag_q  [PAGES];
    logic [OFF_W-1:0]         last_q [PAGES];
    logic [1:0]               fcnt_q [PAGES];
    logic [1:0]               bcnt_q [PAGES];
    logic signed [PTR_W-1:0]  fptr_q [PAGES];
    logic signed [PTR_W-1:0]  bptr_q [PAGES];
    logic [IDX_W-1:0]         age_q  [PAGES];

    logic [TAG_W-1:0] req_tag;
    logic [OFF_W-1:0] req_off;
    assign req_tag = req_line[LINE_W-1:OFF_W];
    assign req_off = req_line[OFF_W-1:0];

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             free_found;
    logic [IDX_W-1:0] vic_idx;
    logic [IDX_W-1:0] tgt_idx;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < PAGES; i++) begin
            if (!hit && val_q[i] && tag_q[i] == req_tag) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        free_found = 1'b0;
        vic_idx    = '0;
        for (int i = 0; i < PAGES; i++) begin
            if (!free_found && !val_q[i]) begin
                free_found = 1'b1;
                vic_idx    = IDX_W'(i);
            end
        end
        if (!free_found) begin
            for (int i = 0; i < PAGES; i++) begin
                if (age_q[i] == OLDEST) vic_idx = IDX_W'(i);
            end
        end
    end

    assign tgt_idx = hit ? hit_idx : vic_idx;

    logic signed [PTR_W-1:0] off_s, last_s, dist_s, ptr, gap, ptr_next;
    logic             step_up, step_dn, fire_f, fire_b, in_page;
    logic [1:0]       f_old, b_old, new_f, new_b;
    logic [OFF_W-1:0] cand_off [2];
    logic [OFF_W:0]   cand_gap [2];

    always_comb begin
        off_s   = $signed({2'b00, req_off});
        last_s  = $signed({2'b00, last_q[hit_idx]});
        dist_s  = $signed({1'b0, dist_lim});
        step_up = hit && (off_s == last_s + ONE_S);
        step_dn = hit && (off_s == last_s - ONE_S);
        f_old   = fcnt_q[hit_idx];
        b_old   = bcnt_q[hit_idx];
        new_f   = step_up ? cnt_bump(f_old) : 2'd0;
        new_b   = step_dn ? cnt_bump(b_old) : 2'd0;
        fire_f  = step_up && (new_f == CNT_CONF);
        fire_b  = step_dn && (new_b == CNT_CONF);

        ptr = '0;
        if (fire_f) begin
            ptr = (f_old == CNT_CONF && fptr_q[hit_idx] > off_s + ONE_S)
                  ? fptr_q[hit_idx] : off_s + ONE_S;
        end else if (fire_b) begin
            ptr = (b_old == CNT_CONF && bptr_q[hit_idx] < off_s - ONE_S)
                  ? bptr_q[hit_idx] : off_s - ONE_S;
        end

        issue_cnt = 2'd0;
        gap       = '0;
        in_page   = 1'b0;
        for (int k = 0; k < 2; k++) begin
            cand_off[k] = '0;
            cand_gap[k] = '0;
        end
        for (int k = 0; k < 2; k++) begin
            gap     = fire_f ? ptr - off_s : off_s - ptr;
            in_page = fire_f ? (ptr <= LAST_S) : (ptr >= ZERO_S);
            if ((fire_f || fire_b) && issue_cnt == 2'(k) && in_page && gap <= dist_s) begin
                cand_off[k] = ptr[OFF_W-1:0];
                cand_gap[k] = gap[OFF_W:0];
                issue_cnt   = issue_cnt + 2'd1;
                ptr         = fire_f ? ptr + ONE_S : ptr - ONE_S;
            end
        end
        ptr_next = ptr;
    end

    assign line_a  = {req_tag, cand_off[0]};
    assign line_b  = {req_tag, cand_off[1]};
    assign ahead_a = cand_gap[0];
    assign ahead_b = cand_gap[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) begin
                val_q[i]  <= 1'b0;
                tag_q[i]  <= '0;
                last_q[i] <= '0;
                fcnt_q[i] <= '0;
                bcnt_q[i] <= '0;
                fptr_q[i] <= '0;
                bptr_q[i] <= '0;
                age_q[i]  <= IDX_W'(i);
            end
        end else if (upd_en) begin
            if (hit) begin
                last_q[hit_idx] <= req_off;
                fcnt_q[hit_idx] <= new_f;
                bcnt_q[hit_idx] <= new_b;
                if (fire_f) fptr_q[hit_idx] <= ptr_next;
                if (fire_b) bptr_q[hit_idx] <= ptr_next;
            end else begin
                val_q[vic_idx]  <= 1'b1;
                tag_q[vic_idx]  <= req_tag;
                last_q[vic_idx] <= req_off;
                fcnt_q[vic_idx] <= '0;
                bcnt_q[vic_idx] <= '0;
            end
            for (int i = 0; i < PAGES; i++) begin
                if (IDX_W'(i) == tgt_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[tgt_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pf_issue_fsm.sv
module pf_issue_fsm
    import pf_pkg::*;
#(
    parameter int LINE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        issue_cnt,
    input  logic [LINE_W-1:0] line_a,
    input  logic [LINE_W-1:0] line_b,
    input  logic              llc_a,
    input  logic              llc_b,
    input  logic              pf_ready,
    output logic              req_ready,
    output logic              upd_en,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    output logic              pf_llc_only
);
    issue_state_t state_q, state_d;

    logic [LINE_W-1:0] held_a_q, held_b_q;
    logic              held_llc_a_q, held_llc_b_q, two_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid && issue_cnt != 2'd0) state_d = ST_SEND_A;
            ST_SEND_A: if (pf_ready) state_d = two_q ? ST_SEND_B : ST_IDLE;
            ST_SEND_B: if (pf_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_a_q     <= '0;
            held_b_q     <= '0;
            held_llc_a_q <= 1'b0;
            held_llc_b_q <= 1'b0;
            two_q        <= 1'b0;
        end else if (upd_en) begin
            held_a_q     <= line_a;
            held_b_q     <= line_b;
            held_llc_a_q <= llc_a;
            held_llc_b_q <= llc_b;
            two_q        <= (issue_cnt == 2'd2);
        end
    end

    always_comb begin
        req_ready   = 1'b0;
        upd_en      = 1'b0;
        pf_valid    = 1'b0;
        pf_line     = '0;
        pf_llc_only = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                upd_en    = req_valid;
            end
            ST_SEND_A: begin
                pf_valid    = 1'b1;
                pf_line     = held_a_q;
                pf_llc_only = held_llc_a_q;
            end
            ST_SEND_B: begin
                pf_valid    = 1'b1;
                pf_line     = held_b_q;
                pf_llc_only = held_llc_b_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
    import pf_pkg::*;
#(
    parameter int LINE_W     = 20,
    parameter int PAGE_BYTES = 4096,
    parameter int LINE_BYTES = 64,
    parameter int STREAMS    = 32,
    parameter int MAX_AHEAD  = 20,
    parameter int FAR_TH     = 8,
    parameter int OUT_W      = 5,
    parameter int LOW_OUT    = 2,
    parameter int HIGH_OUT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LINE_W-1:0] req_line,
    input  logic [OUT_W-1:0]  req_outstanding,
    output logic              req_ready,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    output logic              pf_llc_only,
    input  logic              pf_ready
);
    localparam int OFF_W  = $clog2(PAGE_BYTES / LINE_BYTES);
    localparam int PAGES  = STREAMS / 2;
    localparam int DIST_W = OFF_W + 1;
    localparam logic [OFF_W:0] FAR_LIM = (OFF_W + 1)'(FAR_TH);

    logic [DIST_W-1:0] dist_lim;
    logic              crowded;
    logic              upd_en;
    logic [1:0]        issue_cnt;
    logic [LINE_W-1:0] line_a, line_b;
    logic [OFF_W:0]    ahead_a, ahead_b;
    logic              llc_a, llc_b;

    pf_depth_policy #(
        .OUT_W    (OUT_W),
        .DIST_W   (DIST_W),
        .MAX_AHEAD(MAX_AHEAD),
        .LOW_OUT  (LOW_OUT),
        .HIGH_OUT (HIGH_OUT)
    ) u_policy (
        .outstanding(req_outstanding),
        .dist_lim   (dist_lim),
        .crowded    (crowded)
    );

    pf_stream_table #(
        .LINE_W(LINE_W),
        .OFF_W (OFF_W),
        .PAGES (PAGES)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .req_line (req_line),
        .dist_lim (dist_lim),
        .issue_cnt(issue_cnt),
        .line_a   (line_a),
        .line_b   (line_b),
        .ahead_a  (ahead_a),
        .ahead_b  (ahead_b)
    );

    assign llc_a = crowded || (ahead_a > FAR_LIM);
    assign llc_b = crowded || (ahead_b > FAR_LIM);

    pf_issue_fsm #(
        .LINE_W(LINE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .issue_cnt  (issue_cnt),
        .line_a     (line_a),
        .line_b     (line_b),
        .llc_a      (llc_a),
        .llc_b      (llc_b),
        .pf_ready   (pf_ready),
        .req_ready  (req_ready),
        .upd_en     (upd_en),
        .pf_valid   (pf_valid),
        .pf_line    (pf_line),
        .pf_llc_only(pf_llc_only)
    );

endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter int LINE_W     = 20,
    parameter int PAGE_BYTES = 4096,
    parameter int LINE_BYTES = 64,
    parameter int MAX_AHEAD  = 20,
    parameter int FAR_TH     = 8,
    parameter int OUT_W      = 5,
    parameter int HIGH_OUT   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LINE_W-1:0] req_line,
    input logic [OUT_W-1:0]  req_outstanding,
    input logic              req_ready,
    input logic              pf_valid,
    input logic [LINE_W-1:0] pf_line,
    input logic              pf_llc_only,
    input logic              pf_ready
);
    localparam int OFF_W = $clog2(PAGE_BYTES / LINE_BYTES);

    logic [LINE_W-OFF_W-1:0] cap_page;
    logic [OFF_W-1:0]        cap_off;
    logic                    cap_crowd;
    logic [1:0]              pops;
    logic [OFF_W-1:0]        pf_off;
    int                      ahead;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_page  <= '0;
            cap_off   <= '0;
            cap_crowd <= 1'b0;
            pops      <= '0;
        end else if (req_valid && req_ready) begin
            cap_page  <= req_line[LINE_W-1:OFF_W];
            cap_off   <= req_line[OFF_W-1:0];
            cap_crowd <= (int'(req_outstanding) >= HIGH_OUT);
            pops      <= '0;
        end else if (pf_valid && pf_ready && pops != 2'd3) begin
            pops <= pops + 2'd1;
        end
    end

    assign pf_off = pf_line[OFF_W-1:0];
    assign ahead  = (pf_off > cap_off) ? int'(pf_off - cap_off) : int'(cap_off - pf_off);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_line) && $stable(pf_llc_only));

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !req_ready);

    p_same_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> pf_line[LINE_W-1:OFF_W] == cap_page);

    p_reach_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> ahead >= 1 && ahead <= MAX_AHEAD);

    p_far_llc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && ahead > FAR_TH |-> pf_llc_only);

    p_crowd_llc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && cap_crowd |-> pf_llc_only);

    p_two_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pops <= 2'd2);

    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> !pf_valid && req_ready);

endmodule

bind stream_prefetcher pf_checker #(
    .LINE_W    (LINE_W),
    .PAGE_BYTES(PAGE_BYTES),
    .LINE_BYTES(LINE_BYTES),
    .MAX_AHEAD (MAX_AHEAD),
    .FAR_TH    (FAR_TH),
    .OUT_W     (OUT_W),
    .HIGH_OUT  (HIGH_OUT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_line       (req_line),
    .req_outstanding(req_outstanding),
    .req_ready      (req_ready),
    .pf_valid       (pf_valid),
    .pf_line        (pf_line),
    .pf_llc_only    (pf_llc_only),
    .pf_ready       (pf_ready)
);

// File: tb/stream_prefetcher_tb.sv
module stream_prefetcher_tb;
    localparam int LINE_W = 20;
    localparam int OFF_W  = 6;
    localparam int OUT_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [LINE_W-1:0] req_line = '0;
    logic [OUT_W-1:0]  req_outstanding = '0;
    logic              req_ready;
    logic              pf_valid;
    logic [LINE_W-1:0] pf_line;
    logic              pf_llc_only;
    logic              pf_ready = 1'b1;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    int pg      = 1;

    stream_prefetcher u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .req_outstanding(req_outstanding), .req_ready(req_ready),
        .pf_valid(pf_valid), .pf_line(pf_line), .pf_llc_only(pf_llc_only),
        .pf_ready(pf_ready)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic logic [LINE_W-1:0] mk(input int page, input int off);
        return LINE_W'((page << OFF_W) | off);
    endfunction

    function automatic int dist_of(input int outst);
        if (outst >= 8) return 5;
        if (outst <= 2) return 20;
        return 10;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_req(input logic [LINE_W-1:0] line, input int outst,
                          output int n, output int ln[4], output bit fl[4]);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "req_ready in idle", int'(req_ready), 1);
        req_valid = 1'b1; req_line = line; req_outstanding = OUT_W'(outst); pf_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        for (int i = 0; i < 4; i++) begin ln[i] = 0; fl[i] = 1'b0; end
        while (pf_valid && n < 4) begin
            ln[n] = int'(pf_line);
            fl[n] = pf_llc_only;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic expect_pf(input string rq, input int n, input int ln[4], input bit fl[4],
                             input int en, input int el[2], input bit ef[2]);
        chk(n == en, rq, "prefetch count", n, en);
        for (int i = 0; i < 2; i++) begin
            if (i < en && i < n) begin
                chk(ln[i] == el[i], rq, "prefetch line", ln[i], el[i]);
                chk(fl[i] == ef[i], "R7", "llc_only flag", int'(fl[i]), int'(ef[i]));
            end
        end
    endtask

    // Forward (dir=1) or backward (dir=0) run through one fresh page.
    task automatic run_stream(input bit fwd, input int start, input int outst);
        int n; int ln[4]; bit fl[4]; int el[2]; bit ef[2];
        int ptr, p, en, d, k, o;
        bit crowd;
        d = dist_of(outst);
        crowd = (outst >= 8);
        ptr = 0;
        k = 0;
        o = start;
        while (fwd ? (o <= 63) : (o >= 0)) begin
            do_req(mk(pg, o), outst, n, ln, fl);
            en = 0; el[0] = 0; el[1] = 0; ef[0] = 0; ef[1] = 0;
            if (k >= 2) begin
                if (fwd) p = (k == 2) ? o + 1 : ((ptr > o + 1) ? ptr : o + 1);
                else     p = (k == 2) ? o - 1 : ((ptr < o - 1) ? ptr : o - 1);
                while (en < 2 && (fwd ? (p <= 63 && p - o <= d) : (p >= 0 && o - p <= d))) begin
                    el[en] = int'(mk(pg, p));
                    ef[en] = crowd || ((fwd ? p - o : o - p) > 8);
                    en++;
                    p = fwd ? p + 1 : p - 1;
                end
                ptr = p;
            end
            if (k < 2) expect_pf("R1", n, ln, fl, en, el, ef);
            else if (fwd) expect_pf("R2/R5/R6", n, ln, fl, en, el, ef);
            else expect_pf("R3/R5/R6", n, ln, fl, en, el, ef);
            chk(n <= 2, "R4", "per-request count", n, 2);
            k++;
            o = fwd ? o + 1 : o - 1;
        end
        pg++;
    endtask

    initial begin
        int n; int ln[4]; bit fl[4]; int el[2]; bit ef[2];
        int p0, hold_line;
        int starts_f[3] = '{0, 21, 45};
        int starts_b[3] = '{63, 40, 18};
        int outs[3] = '{0, 5, 12};

        repeat (3) @(negedge clk);
        chk(pf_valid == 1'b0, "R11", "pf_valid in reset", int'(pf_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pf_valid == 1'b0, "R11", "pf_valid after reset", int'(pf_valid), 0);
        chk(req_ready == 1'b1, "R11", "req_ready after reset", int'(req_ready), 1);

        // R11/R9: table starts empty, fill and evict
        p0 = pg; pg++;
        do_req(mk(p0, 10), 0, n, ln, fl); chk(n == 0, "R1", "first request", n, 0);
        do_req(mk(p0, 11), 0, n, ln, fl); chk(n == 0, "R1", "one step", n, 0);
        for (int i = 0; i < 16; i++) begin
            do_req(mk(pg, 30), 0, n, ln, fl); pg++;
        end
        do_req(mk(p0, 12), 0, n, ln, fl);
        chk(n == 0, "R9", "LRU page evicted, count", n, 0);
        do_req(mk(p0, 13), 0, n, ln, fl);
        chk(n == 0, "R9", "retrain after eviction", n, 0);
        do_req(mk(p0, 14), 0, n, ln, fl);
        el[0] = int'(mk(p0, 15)); el[1] = int'(mk(p0, 16)); ef[0] = 0; ef[1] = 0;
        expect_pf("R9", n, ln, fl, 2, el, ef);

        // R9: recently used page survives while older ones go
        p0 = pg; pg++;
        do_req(mk(p0, 10), 0, n, ln, fl);
        do_req(mk(p0, 11), 0, n, ln, fl);
        for (int i = 0; i < 14; i++) begin
            do_req(mk(pg, 5), 0, n, ln, fl); pg++;
        end
        do_req(mk(p0, 12), 0, n, ln, fl);
        el[0] = int'(mk(p0, 13)); el[1] = int'(mk(p0, 14));
        expect_pf("R9", n, ln, fl, 2, el, ef);
        for (int i = 0; i < 15; i++) begin
            do_req(mk(pg, 5), 0, n, ln, fl); pg++;
        end
        do_req(mk(p0, 13), 0, n, ln, fl);
        el[0] = int'(mk(p0, 15)); el[1] = int'(mk(p0, 16));
        expect_pf("R9", n, ln, fl, 2, el, ef);

        // R8: non-unit stride restarts training
        p0 = pg; pg++;
        do_req(mk(p0, 5), 0, n, ln, fl);
        do_req(mk(p0, 6), 0, n, ln, fl);
        do_req(mk(p0, 10), 0, n, ln, fl); chk(n == 0, "R8", "stride break", n, 0);
        do_req(mk(p0, 11), 0, n, ln, fl); chk(n == 0, "R8", "retraining", n, 0);
        do_req(mk(p0, 12), 0, n, ln, fl);
        el[0] = int'(mk(p0, 13)); el[1] = int'(mk(p0, 14));
        expect_pf("R8", n, ln, fl, 2, el, ef);

        // R8/R3: reversal clears forward, confirms backward
        p0 = pg; pg++;
        do_req(mk(p0, 30), 0, n, ln, fl);
        do_req(mk(p0, 31), 0, n, ln, fl);
        do_req(mk(p0, 30), 0, n, ln, fl); chk(n == 0, "R8", "reversal", n, 0);
        do_req(mk(p0, 29), 0, n, ln, fl);
        el[0] = int'(mk(p0, 28)); el[1] = int'(mk(p0, 27));
        expect_pf("R3", n, ln, fl, 2, el, ef);

        // R10: backpressure, hold, busy request ignored
        p0 = pg; pg++;
        do_req(mk(p0, 0), 0, n, ln, fl);
        do_req(mk(p0, 1), 0, n, ln, fl);
        @(negedge clk);
        req_valid = 1'b1; req_line = mk(p0, 2); req_outstanding = '0; pf_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(pf_valid == 1'b1, "R10", "pf_valid raised", int'(pf_valid), 1);
        hold_line = int'(pf_line);
        chk(hold_line == int'(mk(p0, 3)), "R10", "first line", hold_line, int'(mk(p0, 3)));
        req_valid = 1'b1; req_line = mk(p0, 3);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(pf_valid == 1'b1 && int'(pf_line) == hold_line, "R10", "held line",
                int'(pf_line), hold_line);
            chk(req_ready == 1'b0, "R10", "busy req_ready", int'(req_ready), 0);
        end
        req_valid = 1'b0;
        pf_ready = 1'b1;
        @(negedge clk);
        chk(int'(pf_line) == int'(mk(p0, 4)), "R10", "second line", int'(pf_line), int'(mk(p0, 4)));
        @(negedge clk);
        chk(pf_valid == 1'b0, "R10", "drained", int'(pf_valid), 0);
        do_req(mk(p0, 3), 0, n, ln, fl);
        el[0] = int'(mk(p0, 5)); el[1] = int'(mk(p0, 6));
        expect_pf("R10", n, ln, fl, 2, el, ef);

        // Sweeps over start offset, direction and load
        foreach (outs[j]) begin
            foreach (starts_f[i]) run_stream(1'b1, starts_f[i], outs[j]);
            foreach (starts_b[i]) run_stream(1'b0, starts_b[i], outs[j]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule